// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Options

This block is a computer-operating-properly watchdog. It counts bus clock cycles. If software lets the count reach the selected timeout, the block raises a one-cycle reset request to the system reset controller. Software restarts the count by writing to the reset-status address. The watchdog ignores the data of that write and only decodes the address. The reset-status register itself lives elsewhere and is not modified by this block.

The enable and period controls sit in a system options register. That register accepts a single write after each reset. Every later write to it is ignored, so a program that has gone astray cannot turn the watchdog off or lengthen its period. After reset the watchdog is already running with the long timeout. While the debug background mode is active, the count is frozen. All pins are plain control or status signals, and the block has no data stream and no handshake.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 0. After reset is released, the watchdog is enabled with the long period, so the first request comes 2^LONG_EXP counting cycles after release.
- R2: A write (`bus_wr`=1) to `STATUS_ADDR` clears the count whatever the value of `bus_wdata`. The next timeout then comes exactly one full period after the clock edge that took the write.
- R3: Writes to any other address, including `OPT_ADDR`, do not clear the count.
- R4: Bit 0 of the options value is the enable. Writing a 0 there stops the watchdog, and no `rst_req` is raised for as long as it stays disabled.
- R5: Bit 1 of the options value selects the period. A 1 gives 2^LONG_EXP cycles and a 0 gives 2^SHORT_EXP cycles.
- R6: Only the first write to `OPT_ADDR` after a reset takes effect. Every later write leaves the enable and the period unchanged.
- R7: `rst_req` is a one-cycle pulse, issued when the count reaches the selected period. The count restarts from zero on that same edge.
- R8: On each clock edge where `dbg_active` is 1, the count holds. Each such edge therefore delays the timeout by exactly one cycle.
- R9: A service write taken on the same edge that would have reached the timeout suppresses the request and clears the count.
- R10: Asserting `rst_n` clears the write-once lock and restores enable=1 and the long period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | DATA_W | Write data |
| dbg_active | input | 1 | Debug background mode active; freezes the count |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `bus_wr` is a clean level sampled on the clock edge. They also assume that `STATUS_ADDR` and `OPT_ADDR` differ, so one write never both services the counter and sets the options. They further take the options as changing only through that first write, which makes a frozen count under debug meaningful. The stimulus drives every input on the falling edge, holds each write for one cycle and issues no reset in the middle of a write. The bench builds a small configuration (64 and 8 cycle periods), which keeps a full period sweep of every options value short.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic en;        // watchdog running
    logic long_sel;  // 1: long period, 0: short period
  } wdog_opts_t;
endpackage

// File: rtl/wdog_svc_dec.sv
module wdog_svc_dec #(
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              svc
);
  // Only the address matters; write data is never looked at.
  always_comb svc = bus_wr && (bus_addr == STATUS_ADDR);
endmodule

// File: rtl/wdog_opt_reg.sv
module wdog_opt_reg
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 1,
  parameter int EN_BIT  = 0,
  parameter int SEL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wdog_opts_t        opts,
  output logic              locked
);
  logic take;
  always_comb take = bus_wr && (bus_addr == OPT_ADDR) && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opts.en       <= 1'b1;
      opts.long_sel <= 1'b1;
      locked        <= 1'b0;
    end else if (take) begin
      opts.en       <= bus_wdata[EN_BIT];
      opts.long_sel <= bus_wdata[SEL_BIT];
      locked        <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R6
  AST_LOCK_HOLDS_OPTS: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(opts)); // R6
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int LONG_EXP  = 18,
  parameter int SHORT_EXP = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wdog_opts_t opts,
  input  logic       svc,
  input  logic       dbg_active,
  output logic       rst_req
);
  localparam int CNT_W = LONG_EXP;
  localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_EXP) - 64'd1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             hit;

  always_comb begin
    last = opts.long_sel ? LONG_LAST : SHORT_LAST;
    hit  = opts.en && !dbg_active && !svc && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= hit;
      if (!opts.en || svc || hit) cnt <= '0;
      else if (!dbg_active)       cnt <= cnt + 1'b1;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !opts.en |=> !rst_req); // R4
  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && opts.en && !svc) |=> $stable(cnt)); // R8
  AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (!rst_req && cnt == '0)); // R9
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int LONG_EXP  = 18,
  parameter int SHORT_EXP = 13,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 0,
  parameter logic [ADDR_W-1:0] OPT_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              dbg_active,
  output logic              rst_req
);
  wdog_opts_t opts;
  logic       locked;
  logic       svc;

  wdog_svc_dec #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .svc(svc)
  );

  wdog_opt_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_ADDR(OPT_ADDR),
                 .EN_BIT(0), .SEL_BIT(1)) u_opt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .opts(opts), .locked(locked)
  );

  wdog_counter #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .opts(opts), .svc(svc),
    .dbg_active(dbg_active), .rst_req(rst_req)
  );

  AST_RESET_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (opts.en && opts.long_sel)); // R10
endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
  localparam int LE = 6;
  localparam int SE = 3;
  localparam int LP = 1 << LE;
  localparam int SP = 1 << SE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       dbg_active = 1'b0;
  logic       rst_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdog_top #(.ADDR_W(8), .DATA_W(8), .LONG_EXP(LE), .SHORT_EXP(SE),
             .STATUS_ADDR(8'h00), .OPT_ADDR(8'h01)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .dbg_active(dbg_active), .rst_req(rst_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rst_req == 1'b0, "R1 reset low", rst_req, 0);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Counts edges from the current falling edge to the first rst_req.
  task automatic measure(input int dbg_n, input int exp, input string req);
    int n = 0;
    forever begin
      dbg_active = (n < dbg_n);
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rst_req || n > 4 * exp + 16) break;
    end
    dbg_active = 1'b0;
    check(n == exp, req, n, exp);
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_req) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: default long period from reset
    do_reset();
    measure(0, LP, "R1 default long period");
    // R7: pulse lasts one cycle, count restarts
    @(posedge clk); @(negedge clk);
    check(rst_req == 1'b0, "R7 pulse width", rst_req, 0);
    measure(0, LP - 1, "R7 restart after timeout");

    // R2: service with several data values
    for (int k = 0; k < 4; k++) begin
      logic [7:0] dv;
      dv = 8'(k * 8'h55);
      repeat (5 + k) @(negedge clk);
      do_write(8'h00, dv);
      measure(0, LP, "R2 service any data");
    end

    // R3: writes to other addresses do not service
    do_reset();
    for (int a = 2; a < 12; a++) do_write(8'(a), 8'hFF);
    measure(0, LP - 10, "R3 other addresses ignored");
    do_reset();
    do_write(8'h01, 8'h03);
    measure(0, LP - 1, "R3 option write does not service");

    // R4/R5: sweep of all option values
    for (int o = 0; o < 4; o++) begin
      do_reset();
      do_write(8'h01, 8'(o));
      do_write(8'h00, 8'h00);
      if (o[0]) measure(0, o[1] ? LP : SP, "R5 period select");
      else      quiet(4 * LP, "R4 disabled no request");
    end

    // R6: write-once lock
    do_reset();
    do_write(8'h01, 8'h00);
    do_write(8'h01, 8'h03);
    do_write(8'h00, 8'h00);
    quiet(4 * LP, "R6 re-enable ignored");
    do_reset();
    do_write(8'h01, 8'h01);
    do_write(8'h01, 8'h03);
    do_write(8'h00, 8'h00);
    measure(0, SP, "R6 period change ignored");

    // R10: reset clears lock and restores defaults
    do_reset();
    measure(0, LP, "R10 defaults after reset");
    do_write(8'h01, 8'h01);
    do_write(8'h00, 8'h00);
    measure(0, SP, "R10 lock cleared by reset");

    // R8: debug freeze
    for (int d = 1; d < 20; d += 6) begin
      do_reset();
      measure(d, LP + d, "R8 debug freeze");
    end

    // R9: service on the timeout edge wins
    do_reset();
    repeat (LP - 1) begin @(posedge clk); @(negedge clk); end
    check(rst_req == 1'b0, "R9 before edge", rst_req, 0);
    do_write(8'h00, 8'hA5);
    check(rst_req == 1'b0, "R9 service wins", rst_req, 0);
    measure(0, LP, "R9 count cleared");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule